// File: doc/BRIEF.md
# Programmable Flag Pin Controller with Interrupts

This block manages sixteen general-purpose flag pins behind a small register bus. Every pin is either an input or an output, chosen by its own direction bit. Output pins drive the value that software holds in the data register. Input pins pass through a two-stage synchronizer, and their settled value is loaded back into the same data register so that software reads it there. Data bits and interrupt enables are never written whole. Software changes them through a pair of addresses: ones written to the first address set bits, and ones written to the second clear them.

Each pin has its own interrupt channel with a selectable polarity and a choice of level or edge detection. In edge mode the pin can react to the active-going edge only or to both edges. An enabled input pin acts as a hardware interrupt source. An enabled output pin raises an interrupt from the value software drives onto it, which makes it a software interrupt source. Edge events stay latched until software writes a one to the pin's bit at the pending address. A level request follows the pin.

Each channel is a three-state machine. In `CH_OFF` the pin is masked. In `CH_WATCH` it is enabled and idle. In `CH_HELD` a request is asserted. The transitions are:
- `arm` (`CH_OFF`→`CH_WATCH`): the mask bit is set.
- `fire` (`CH_WATCH`→`CH_HELD`): the pin is at its active level in level mode, or a qualifying edge occurs in edge mode.
- `release` (`CH_HELD`→`CH_WATCH`): the pin goes inactive in level mode, or the pending bit is cleared in edge mode with no new edge in the same cycle.
- `disarm` (`CH_WATCH`/`CH_HELD`→`CH_OFF`): the mask bit is cleared. This discards any pending request.

Top module: `flag_pins`

## Requirements
- R1: After reset every register reads zero: direction, data, mask, polarity, sense, both-edge and pending. pin_oe and irq are also zero.
- R2: Address 0x0 holds the direction register, and a bit of 1 makes that pin an output. pin_oe equals the direction register.
- R3: Writing ones to address 0x1 sets those data bits and writing ones to address 0x2 clears them. Zero bits leave data unchanged. pin_out carries the data bits of output pins and 0 in the positions of input pins.
- R4: At input positions, reading address 0x1 or 0x2 returns pin_in three clock edges after it changes. Set and clear writes to input positions have no effect.
- R5: Writing ones to address 0x3 enables interrupts for those pins and writing ones to address 0x4 disables them. Both addresses read back the mask.
- R6: Address 0x5 holds the polarity register. A bit of 1 makes the pin active-low and a bit of 0 makes it active-high.
- R7: Address 0x6 holds the sense register, where 0 selects level mode and 1 selects edge mode. In level mode, an enabled pin's irq bit is high while the pin is at its active level and falls once the pin goes inactive.
- R8: In edge mode with its bit at address 0x7 equal to 0, an inactive-to-active transition latches irq. The request holds until a 1 is written to that bit at address 0x8, and writing 0 there leaves it set. The opposite transition does nothing.
- R9: In edge mode with its bit at address 0x7 equal to 1, either transition latches the request.
- R10: An enabled output pin raises irq from the software-written data value.
- R11: A masked pin never asserts irq. Clearing its mask drops any pending request, and re-enabling the mask does not bring it back.
- R12: Reading address 0x8 returns the current irq vector.
- R13: In level mode, an input change reaches irq on the fourth clock edge after it is applied and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for addr (combinational) |
| pin_in | input | 16 | Pin input levels |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Pin output enables |
| irq | output | 16 | Per-pin interrupt requests |

## Verification
Some properties are checked on every cycle. A masked channel must be quiet one cycle later. An edge request must hold until it is cleared. A level request must drop when its pin goes inactive. Set and clear writes must reach the data and mask registers on the next edge.

Other behaviour only the bench scenarios can show. These are the end-to-end latency through the synchronizer, the polarity inversion, the difference between rising-only and both-edge detection, and software interrupts from output pins. They also include the rule that writes to input positions are overwritten and that re-enabling a mask does not revive a discarded request.

// File: rtl/flag_pins_pkg.sv
package flag_pins_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_DIR   = 4'h0,
        RA_DSET  = 4'h1,
        RA_DCLR  = 4'h2,
        RA_MSET  = 4'h3,
        RA_MCLR  = 4'h4,
        RA_POL   = 4'h5,
        RA_SENSE = 4'h6,
        RA_BOTH  = 4'h7,
        RA_PEND  = 4'h8
    } reg_addr_e;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_WATCH = 2'd1,
        CH_HELD  = 2'd2
    } chan_state_e;

endpackage

// File: rtl/flag_pins_sync.sv
module flag_pins_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/flag_pins_regs.sv
module flag_pins_regs
    import flag_pins_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  rd_data,
    input  logic [NPINS-1:0]  sync_in,
    input  logic [NPINS-1:0]  irq_in,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  mask_q,
    output logic [NPINS-1:0]  pol_q,
    output logic [NPINS-1:0]  edge_q,
    output logic [NPINS-1:0]  both_q,
    output logic [NPINS-1:0]  pend_clr
);

    logic [NPINS-1:0] dset_v, dclr_v, mset_v, mclr_v;
    logic [NPINS-1:0] data_sw, data_d;

    always_comb begin
        dset_v   = '0;
        dclr_v   = '0;
        mset_v   = '0;
        mclr_v   = '0;
        pend_clr = '0;
        if (wr_en) begin
            unique case (addr)
                RA_DSET: dset_v   = wr_data;
                RA_DCLR: dclr_v   = wr_data;
                RA_MSET: mset_v   = wr_data;
                RA_MCLR: mclr_v   = wr_data;
                RA_PEND: pend_clr = wr_data;
                default: ;
            endcase
        end
    end

    // Output positions keep the software value; input positions reload from the pins.
    assign data_sw = (data_q | dset_v) & ~dclr_v;
    assign data_d  = (dir_q & data_sw) | (~dir_q & sync_in);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '0;
            mask_q <= '0;
            pol_q  <= '0;
            edge_q <= '0;
            both_q <= '0;
        end else begin
            data_q <= data_d;
            mask_q <= (mask_q | mset_v) & ~mclr_v;
            if (wr_en && addr == RA_DIR)   dir_q  <= wr_data;
            if (wr_en && addr == RA_POL)   pol_q  <= wr_data;
            if (wr_en && addr == RA_SENSE) edge_q <= wr_data;
            if (wr_en && addr == RA_BOTH)  both_q <= wr_data;
        end
    end

    always_comb begin
        unique case (addr)
            RA_DIR:           rd_data = dir_q;
            RA_DSET, RA_DCLR: rd_data = data_q;
            RA_MSET, RA_MCLR: rd_data = mask_q;
            RA_POL:           rd_data = pol_q;
            RA_SENSE:         rd_data = edge_q;
            RA_BOTH:          rd_data = both_q;
            RA_PEND:          rd_data = irq_in;
            default:          rd_data = '0;
        endcase
    end

    // R3: ones written to the set address appear at output positions next cycle
    a_r3_data_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_DSET) |=>
            ((data_q & $past(dir_q & wr_data)) == $past(dir_q & wr_data)));

    // R3: ones written to the clear address are zero at output positions next cycle
    a_r3_data_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_DCLR) |=>
            ((data_q & $past(dir_q & wr_data)) == '0));

    // R5: mask clear takes effect on the next edge
    a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_MCLR) |=> ((mask_q & $past(wr_data)) == '0));

endmodule

// File: rtl/flag_pins_chan.sv
module flag_pins_chan
    import flag_pins_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mask_i,
    input  logic src_i,
    input  logic pol_i,
    input  logic edge_i,
    input  logic both_i,
    input  logic clr_i,
    output logic irq_o
);

    chan_state_e state_q, state_d;
    logic active, prev_q, hit_edge;

    assign active   = src_i ^ pol_i;
    assign hit_edge = both_i ? (active ^ prev_q) : (active & ~prev_q);

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (mask_i) state_d = CH_WATCH;                  // arm
            end
            CH_WATCH: begin
                if (!mask_i)                     state_d = CH_OFF;  // disarm
                else if (edge_i ? hit_edge : active) state_d = CH_HELD; // fire
            end
            CH_HELD: begin
                if (!mask_i)                         state_d = CH_OFF;   // disarm
                else if (edge_i && clr_i && !hit_edge) state_d = CH_WATCH; // release
                else if (!edge_i && !active)         state_d = CH_WATCH; // release
            end
            default: state_d = CH_OFF;
        endcase
    end

    always_comb begin
        irq_o = (state_q == CH_HELD);
    end

    // R11: a masked channel is quiet on the next cycle
    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_i |=> !irq_o);

    // R8: an edge request holds until it is cleared
    a_r8_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HELD && edge_i && mask_i && !clr_i) |=> irq_o);

    // R7: a level request drops once the pin goes inactive
    a_r7_level_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HELD && !edge_i && mask_i && !active) |=> !irq_o);

endmodule

// File: rtl/flag_pins.sv
module flag_pins
    import flag_pins_pkg::*;
#(
    parameter int NPINS       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  rd_data,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  irq
);

    logic [NPINS-1:0] sync_in;
    logic [NPINS-1:0] dir_q, data_q, mask_q, pol_q, edge_q, both_q, pend_clr;

    flag_pins_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (sync_in)
    );

    flag_pins_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .sync_in  (sync_in),
        .irq_in   (irq),
        .dir_q    (dir_q),
        .data_q   (data_q),
        .mask_q   (mask_q),
        .pol_q    (pol_q),
        .edge_q   (edge_q),
        .both_q   (both_q),
        .pend_clr (pend_clr)
    );

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_chan
            flag_pins_chan u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .mask_i (mask_q[p]),
                .src_i  (data_q[p]),
                .pol_i  (pol_q[p]),
                .edge_i (edge_q[p]),
                .both_i (both_q[p]),
                .clr_i  (pend_clr[p]),
                .irq_o  (irq[p])
            );
        end
    endgenerate

    assign pin_oe  = dir_q;
    assign pin_out = data_q & dir_q;

endmodule

// File: tb/flag_pins_test.sv
module flag_pins_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    flag_pins uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [3:0]  wa;
        logic [15:0] wd;
        logic [3:0]  ra;
        logic [15:0] ex;
    } vec_t;

    localparam vec_t TBL [9] = '{
        '{4'h0, 16'h00FF, 4'h0, 16'h00FF},
        '{4'h1, 16'hF00F, 4'h1, 16'h000F},
        '{4'h2, 16'h0003, 4'h2, 16'h000C},
        '{4'h3, 16'h1234, 4'h3, 16'h1234},
        '{4'h3, 16'h0001, 4'h4, 16'h1235},
        '{4'h4, 16'h1030, 4'h3, 16'h0205},
        '{4'h5, 16'hA5A5, 4'h5, 16'hA5A5},
        '{4'h6, 16'h00F0, 4'h6, 16'h00F0},
        '{4'h7, 16'h0F00, 4'h7, 16'h0F00}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pin_in = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    logic [15:0] v;

    initial begin
        // R2 R3 R5 R6 R7 R8 R9: register table
        do_reset();
        for (int i = 0; i < 9; i++) begin
            wr(TBL[i].wa, TBL[i].wd);
            step(1);
            rd(TBL[i].ra, v);
            chk($sformatf("R2 R3 R5 R6 R7 R8 R9 table entry %0d", i), v, TBL[i].ex);
        end

        // R1: reset state
        do_reset();
        for (int a = 0; a <= 8; a++) begin
            rd(a[3:0], v);
            chk($sformatf("R1 reset read addr %0d", a), v, 16'h0000);
        end
        chk("R1 reset pin_oe", pin_oe, 16'h0000);
        chk("R1 reset irq", irq, 16'h0000);

        // R2: direction drives output enable
        wr(4'h0, 16'h8001);
        chk("R2 pin_oe follows direction", pin_oe, 16'h8001);

        // R3: set/clear on output pins; inputs show zero on pin_out
        wr(4'h1, 16'hFFFF);
        chk("R3 set drives outputs only", pin_out, 16'h8001);
        wr(4'h2, 16'h0001);
        chk("R3 clear bit 0", pin_out, 16'h8000);
        wr(4'h2, 16'h0000);
        chk("R3 zero clear no effect", pin_out, 16'h8000);

        // R4: inputs captured into data; writes at input positions ignored
        pin_in = 16'h0F0F;
        step(4);
        rd(4'h1, v);
        chk("R4 input capture", v, 16'h8F0E);
        wr(4'h2, 16'h0F0E);
        rd(4'h2, v);
        chk("R4 clear at inputs ignored", v, 16'h8F0E);

        // R13 and R7: level latency and release
        do_reset();
        wr(4'h3, 16'h0004);
        step(2);
        pin_in = 16'h0004;
        step(3);
        chk("R13 no irq after three edges", irq, 16'h0000);
        step(1);
        chk("R13 irq on fourth edge", irq, 16'h0004);
        chk("R7 level irq asserted", irq, 16'h0004);
        pin_in = 16'h0000;
        step(6);
        chk("R7 level irq released", irq, 16'h0000);

        // R6: active-low polarity
        do_reset();
        wr(4'h5, 16'h0008);
        wr(4'h3, 16'h0008);
        step(6);
        chk("R6 active-low pin low raises irq", irq, 16'h0008);
        pin_in = 16'h0008;
        step(6);
        chk("R6 active-low pin high quiet", irq, 16'h0000);

        // R8 R12: rising-only edge
        do_reset();
        wr(4'h6, 16'h0010);
        wr(4'h3, 16'h0010);
        step(2);
        pin_in = 16'h0010;
        step(6);
        chk("R8 rising edge latches", irq, 16'h0010);
        pin_in = 16'h0000;
        step(6);
        chk("R8 request held after pin drops", irq, 16'h0010);
        rd(4'h8, v);
        chk("R12 pending read", v, 16'h0010);
        wr(4'h8, 16'h0000);
        step(2);
        chk("R8 zero write keeps pending", irq, 16'h0010);
        wr(4'h8, 16'h0010);
        step(2);
        chk("R8 one write clears pending", irq, 16'h0000);
        pin_in = 16'h0010;
        step(6);
        chk("R8 second rising edge", irq, 16'h0010);
        wr(4'h8, 16'h0010);
        step(2);
        chk("R8 cleared while pin high", irq, 16'h0000);
        pin_in = 16'h0000;
        step(6);
        chk("R8 falling edge ignored", irq, 16'h0000);

        // R9: both edges
        wr(4'h6, 16'h0030);
        wr(4'h7, 16'h0020);
        wr(4'h3, 16'h0020);
        step(2);
        pin_in = 16'h0020;
        step(6);
        chk("R9 rising edge latches", irq, 16'h0020);
        wr(4'h8, 16'h0020);
        step(2);
        chk("R9 cleared", irq, 16'h0000);
        pin_in = 16'h0000;
        step(6);
        chk("R9 falling edge latches", irq, 16'h0020);
        wr(4'h8, 16'h0020);
        step(2);
        chk("R9 cleared again", irq, 16'h0000);

        // R10: software interrupt from an output pin
        wr(4'h0, 16'h0040);
        wr(4'h3, 16'h0040);
        step(2);
        wr(4'h1, 16'h0040);
        step(2);
        chk("R10 software interrupt raised", irq, 16'h0040);
        wr(4'h2, 16'h0040);
        step(2);
        chk("R10 software interrupt dropped", irq, 16'h0000);

        // R11: masked pins stay quiet; mask clear discards pending
        pin_in = 16'h0080;
        step(6);
        chk("R11 masked level pin quiet", irq, 16'h0000);
        pin_in = 16'h0090;
        step(6);
        chk("R11 setup pending on bit 4", irq, 16'h0010);
        wr(4'h4, 16'h0010);
        step(1);
        chk("R11 mask clear drops request", irq, 16'h0000);
        wr(4'h3, 16'h0010);
        step(2);
        chk("R11 re-enable does not revive", irq, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule